// File: doc/BRIEF.md
# Chip RAM Alias Decoder

This block sits between a CPU bus and the chip RAM array. A fixed 2 MiB select window begins at address zero. Inside that window, the CPU address is reduced to a RAM offset by a mask. The mask depends on the DMA address reach of the chipset revision in use. A part with 512 KiB or 1 MiB of reach ignores the upper window address bits, so the fitted RAM shows up again at every multiple of its reach. A 2 MiB part decodes the whole window, and its RAM appears only once.

Within one image, the block compares the masked offset with the fitted RAM size. An access that reaches past the end of the fitted RAM gets no RAM response and acts as open bus: a read returns all ones, and a write is discarded. The block drives a word-wide asynchronous-read RAM port with big-endian byte lanes. It returns read data right-justified. For every write that lands, it presents the bus address to the write-watch logic, and it also presents the canonical offset whenever the two differ.

Every access takes exactly one clock cycle. The result appears one cycle after the strobe.

Top module: `cram_alias_dec`

## Requirements
- R1: An access with any address bit at or above bit 21 set (address >= 0x200000) never hits.
- R2: With reach select 0 (512 KiB), the offset is the address ANDed with 0x7FFFF, so the image repeats at 0x080000, 0x100000 and 0x180000.
- R3: With reach select 1 (1 MiB), the offset is the address ANDed with 0xFFFFF, so the image repeats only at 0x100000.
- R4: With reach select 2 (2 MiB), or with the reserved code 3, the offset equals the address and the image does not repeat.
- R5: An access hits only when offset plus access byte count is at most the fitted size. An access that straddles the end of the fitted RAM misses as a whole.
- R6: On a miss, a read returns 0xFFFFFFFF and a write leaves RAM contents unchanged.
- R7: A fitted size of zero gives no hit anywhere.
- R8: Size code 0 is a byte, code 1 a word and code 2 a long. Data is big-endian: the lowest address holds the most significant byte. Read data is right-justified.
- R9: A word at an odd address, a long at an address that is not a multiple of 4, and size code 3 all miss.
- R10: The alias flag is set exactly when the access hits and the offset differs from the address.
- R11: A write hit raises the write note with the bus address. When the bus address and the offset differ, the block also raises the canonical note with the offset.
- R12: The reach select is captured only in cycles with no strobe. An access uses the reach captured before its own cycle.
- R13: The response (valid, hit, offset, alias, read data, write notes and RAM strobe) appears in the cycle after the strobe cycle. Out of reset, nothing is valid and read data is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe; wins over rd_en |
| acc_addr | input | 24 | CPU byte address |
| acc_size | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| wr_data | input | 32 | Write data, right-justified |
| reach_sel | input | 2 | 0: 512 KiB, 1: 1 MiB, 2 or 3: 2 MiB |
| fitted_size | input | 22 | Fitted RAM size in bytes (0 to 0x200000) |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_hit | output | 1 | The access reached RAM |
| rsp_offset | output | 21 | Masked canonical offset |
| rsp_alias | output | 1 | Hit through a repeated image |
| rd_data | output | 32 | Read data, all ones unless it is a read hit |
| wn_valid | output | 1 | A write landed in RAM |
| wn_bus_addr | output | 24 | Bus address of that write |
| wn_chip_valid | output | 1 | The canonical address differs and is presented |
| wn_chip_addr | output | 21 | Canonical offset of that write |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | 19 | RAM word address |
| ram_be | output | 4 | Byte enables, bit 3 is the lowest address |
| ram_wdata | output | 32 | Lane-placed write data |
| ram_rdata | input | 32 | Asynchronous read word from RAM |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- that addresses outside the window and a zero fitted size never hit;
- that every hit ends inside the fitted RAM;
- that a miss drives all ones and no RAM strobe;
- that the alias flag and the canonical write note only appear with a hit and with differing addresses.

Only the bench's scenarios can show:
- the per-revision mirror positions;
- big-endian lane placement through aliased writes and reads;
- that dropped writes leave memory untouched;
- that a reach change coinciding with an access is held back until an idle cycle.

// File: rtl/cram_pkg.sv
package cram_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int LANES  = 4;
  localparam int DATA_W = LANES * 8;

  // Byte count of an access; zero marks an illegal size.
  function automatic logic [2:0] size_bytes(acc_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      SZ_LONG: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/cram_reach_mask.sv
module cram_reach_mask #(
  parameter int WIN_LOG2       = 21,
  parameter int MIN_REACH_LOG2 = 19,
  parameter int SEL_W          = 2
) (
  input  logic [SEL_W-1:0]    reach_sel,
  output logic [WIN_LOG2-1:0] mask
);
  localparam int NUM_REACH = WIN_LOG2 - MIN_REACH_LOG2 + 1;
  localparam logic [SEL_W:0] NUM_REACH_V = NUM_REACH[SEL_W:0];

  logic [WIN_LOG2-1:0] mask_tab [NUM_REACH];

  // One mask per reach step, each doubling the decoded span.
  for (genvar g = 0; g < NUM_REACH; g++) begin : g_mask
    assign mask_tab[g] = {WIN_LOG2{1'b1}} >> (NUM_REACH - 1 - g);
  end

  always_comb begin
    if ({1'b0, reach_sel} < NUM_REACH_V) begin
      mask = mask_tab[reach_sel];
    end else begin
      mask = mask_tab[NUM_REACH-1];
    end
  end

endmodule

// File: rtl/cram_bound_check.sv
module cram_bound_check
  import cram_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 21
) (
  input  logic [ADDR_W-1:0]   addr,
  input  acc_size_e           size,
  input  logic [WIN_LOG2:0]   fitted,
  input  logic [WIN_LOG2-1:0] mask,
  output logic                hit,
  output logic                is_alias,
  output logic [WIN_LOG2-1:0] offset
);
  logic              in_win;
  logic              aligned;
  logic [2:0]        nbytes;
  logic [WIN_LOG2:0] end_pos;

  always_comb begin
    offset  = addr[WIN_LOG2-1:0] & mask;
    in_win  = (addr[ADDR_W-1:WIN_LOG2] == '0);
    nbytes  = size_bytes(size);
    case (size)
      SZ_BYTE: aligned = 1'b1;
      SZ_WORD: aligned = ~addr[0];
      SZ_LONG: aligned = (addr[1:0] == 2'b00);
      default: aligned = 1'b0;
    endcase
    end_pos  = {1'b0, offset} + {{(WIN_LOG2-2){1'b0}}, nbytes};
    hit      = in_win && aligned && (nbytes != 3'd0) && (end_pos <= fitted);
    is_alias = hit && (offset != addr[WIN_LOG2-1:0]);
  end

endmodule

// File: rtl/cram_lane_map.sv
module cram_lane_map
  import cram_pkg::*;
(
  input  acc_size_e          size,
  input  logic [1:0]         lane,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic [LANES-1:0]   be,
  output logic [DATA_W-1:0]  lane_wdata,
  output logic [DATA_W-1:0]  rd_val
);
  // Big-endian: byte lane 3 (bits 31:24) holds the lowest address.
  always_comb begin
    case (size)
      SZ_BYTE: begin
        be         = 4'b1000 >> lane;
        lane_wdata = {4{wr_data[7:0]}};
        rd_val     = (ram_rdata >> {~lane, 3'b000}) & 32'h0000_00FF;
      end
      SZ_WORD: begin
        be         = lane[1] ? 4'b0011 : 4'b1100;
        lane_wdata = {2{wr_data[15:0]}};
        rd_val     = lane[1] ? {16'd0, ram_rdata[15:0]} : {16'd0, ram_rdata[31:16]};
      end
      SZ_LONG: begin
        be         = 4'b1111;
        lane_wdata = wr_data;
        rd_val     = ram_rdata;
      end
      default: begin
        be         = 4'b0000;
        lane_wdata = '0;
        rd_val     = '1;
      end
    endcase
  end

endmodule

// File: rtl/cram_alias_dec.sv
module cram_alias_dec
  import cram_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int WIN_LOG2       = 21,
  parameter int MIN_REACH_LOG2 = 19,
  parameter int SEL_W          = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [1:0]            acc_size,
  input  logic [31:0]           wr_data,
  input  logic [SEL_W-1:0]      reach_sel,
  input  logic [WIN_LOG2:0]     fitted_size,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [WIN_LOG2-1:0]   rsp_offset,
  output logic                  rsp_alias,
  output logic [31:0]           rd_data,
  output logic                  wn_valid,
  output logic [ADDR_W-1:0]     wn_bus_addr,
  output logic                  wn_chip_valid,
  output logic [WIN_LOG2-1:0]   wn_chip_addr,
  output logic                  ram_en,
  output logic                  ram_we,
  output logic [WIN_LOG2-3:0]   ram_waddr,
  output logic [3:0]            ram_be,
  output logic [31:0]           ram_wdata,
  input  logic [31:0]           ram_rdata
);
  localparam int OFF_W = WIN_LOG2;

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  logic strobe;
  assign strobe = rd_en | wr_en;

  // Reach capture: only while the bus is idle.
  logic [SEL_W-1:0] reach_q, reach_d;
  always_comb reach_d = strobe ? reach_q : reach_sel;

  logic [OFF_W-1:0] mask;
  cram_reach_mask #(
    .WIN_LOG2      (WIN_LOG2),
    .MIN_REACH_LOG2(MIN_REACH_LOG2),
    .SEL_W         (SEL_W)
  ) u_mask (
    .reach_sel(reach_q),
    .mask     (mask)
  );

  logic             dec_hit, dec_alias;
  logic [OFF_W-1:0] dec_off;
  cram_bound_check #(
    .ADDR_W  (ADDR_W),
    .WIN_LOG2(WIN_LOG2)
  ) u_bound (
    .addr    (acc_addr),
    .size    (acc_size_e'(acc_size)),
    .fitted  (fitted_size),
    .mask    (mask),
    .hit     (dec_hit),
    .is_alias(dec_alias),
    .offset  (dec_off)
  );

  // Response stage.
  logic              valid_q, valid_d;
  logic              write_q, write_d;
  logic              hit_q, hit_d;
  logic              alias_q, alias_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [ADDR_W-1:0] bus_q, bus_d;
  logic [1:0]        size_q, size_d;
  logic [31:0]       wdat_q, wdat_d;

  always_comb begin
    valid_d = strobe;
    write_d = write_q;
    hit_d   = hit_q;
    alias_d = alias_q;
    off_d   = off_q;
    bus_d   = bus_q;
    size_d  = size_q;
    wdat_d  = wdat_q;
    if (strobe) begin
      write_d = wr_en;
      hit_d   = dec_hit;
      alias_d = dec_alias;
      off_d   = dec_off;
      bus_d   = acc_addr;
      size_d  = acc_size;
      wdat_d  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      reach_q <= '0;
      valid_q <= 1'b0;
      write_q <= 1'b0;
      hit_q   <= 1'b0;
      alias_q <= 1'b0;
      off_q   <= '0;
      bus_q   <= '0;
      size_q  <= '0;
      wdat_q  <= '0;
    end else begin
      reach_q <= reach_d;
      valid_q <= valid_d;
      if (strobe) begin
        write_q <= write_d;
        hit_q   <= hit_d;
        alias_q <= alias_d;
        off_q   <= off_d;
        bus_q   <= bus_d;
        size_q  <= size_d;
        wdat_q  <= wdat_d;
      end
    end
  end

  logic [31:0] rd_val;
  logic [3:0]  lane_be;
  logic [31:0] lane_wdata;
  cram_lane_map u_lane (
    .size      (acc_size_e'(size_q)),
    .lane      (off_q[1:0]),
    .wr_data   (wdat_q),
    .ram_rdata (ram_rdata),
    .be        (lane_be),
    .lane_wdata(lane_wdata),
    .rd_val    (rd_val)
  );

  logic landed;
  assign landed = valid_q & hit_q;

  always_comb begin
    rsp_valid     = valid_q;
    rsp_hit       = landed;
    rsp_offset    = off_q;
    rsp_alias     = landed & alias_q;
    rd_data       = (landed && !write_q) ? rd_val : '1;
    ram_en        = landed;
    ram_we        = landed & write_q;
    ram_waddr     = off_q[OFF_W-1:2];
    ram_be        = lane_be;
    ram_wdata     = lane_wdata;
    wn_valid      = landed & write_q;
    wn_bus_addr   = bus_q;
    wn_chip_valid = landed & write_q & alias_q;
    wn_chip_addr  = off_q;
  end

endmodule

// File: rtl/cram_alias_dec_chk.sv
module cram_alias_dec_chk #(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 21
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_en,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   acc_addr,
  input logic [1:0]          acc_size,
  input logic [WIN_LOG2:0]   fitted_size,
  input logic                rsp_valid,
  input logic                rsp_hit,
  input logic [WIN_LOG2-1:0] rsp_offset,
  input logic                rsp_alias,
  input logic [31:0]         rd_data,
  input logic                wn_valid,
  input logic [ADDR_W-1:0]   wn_bus_addr,
  input logic                wn_chip_valid,
  input logic [WIN_LOG2-1:0] wn_chip_addr,
  input logic                ram_en
);
  function automatic logic [WIN_LOG2:0] nb(logic [1:0] s);
    case (s)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 0;
    endcase
  endfunction

  a_r13_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |=> rsp_valid);

  a_r13_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |=> !rsp_valid);

  a_r1_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && acc_addr[ADDR_W-1:WIN_LOG2] != '0) |=> !rsp_hit);

  a_r7_zero_fitted: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && fitted_size == '0) |=> !rsp_hit);

  a_r5_within_fitted: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |->
      ({1'b0, rsp_offset} + nb($past(acc_size))) <= $past(fitted_size));

  a_r6_open_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_hit) |-> (rd_data == 32'hFFFF_FFFF && !ram_en));

  a_r10_alias_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_alias |-> rsp_hit);

  a_r11_chip_note: assert property (@(posedge clk) disable iff (!rst_n)
    wn_chip_valid |-> (wn_valid && wn_chip_addr != wn_bus_addr[WIN_LOG2-1:0]));

endmodule

bind cram_alias_dec cram_alias_dec_chk #(
  .ADDR_W  (ADDR_W),
  .WIN_LOG2(WIN_LOG2)
) u_chk (
  .clk          (clk),
  .rst_n        (core_rst_n),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .acc_addr     (acc_addr),
  .acc_size     (acc_size),
  .fitted_size  (fitted_size),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_offset   (rsp_offset),
  .rsp_alias    (rsp_alias),
  .rd_data      (rd_data),
  .wn_valid     (wn_valid),
  .wn_bus_addr  (wn_bus_addr),
  .wn_chip_valid(wn_chip_valid),
  .wn_chip_addr (wn_chip_addr),
  .ram_en       (ram_en)
);

// File: tb/cram_alias_dec_tb.sv
module cram_alias_dec_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [23:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  reach_sel = '0;
  logic [21:0] fitted_size = 22'h08_0000;
  logic        rsp_valid, rsp_hit, rsp_alias;
  logic [20:0] rsp_offset, wn_chip_addr;
  logic [31:0] rd_data, ram_wdata, ram_rdata;
  logic        wn_valid, wn_chip_valid, ram_en, ram_we;
  logic [23:0] wn_bus_addr;
  logic [18:0] ram_waddr;
  logic [3:0]  ram_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  cram_alias_dec u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .acc_addr(acc_addr), .acc_size(acc_size), .wr_data(wr_data),
    .reach_sel(reach_sel), .fitted_size(fitted_size),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_offset(rsp_offset),
    .rsp_alias(rsp_alias), .rd_data(rd_data), .wn_valid(wn_valid),
    .wn_bus_addr(wn_bus_addr), .wn_chip_valid(wn_chip_valid),
    .wn_chip_addr(wn_chip_addr), .ram_en(ram_en), .ram_we(ram_we),
    .ram_waddr(ram_waddr), .ram_be(ram_be), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  // RAM model: asynchronous read, byte-enabled synchronous write.
  logic [31:0] mem [0:524287];
  assign ram_rdata = mem[ram_waddr];
  always @(posedge clk) begin
    if (ram_we) begin
      for (int i = 0; i < 4; i++) begin
        if (ram_be[i]) mem[ram_waddr][8*i +: 8] <= ram_wdata[8*i +: 8];
      end
    end
  end

  typedef struct {
    bit          is_wr;
    bit          hit;
    logic [20:0] off;
    bit          als;
    logic [31:0] rdata;
    logic [23:0] addr;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  exp_t        cur;
  int          n_checks = 0;
  int          n_fails = 0;
  bit          finished = 0;
  logic [1:0]  cur_reach = 2'd0;
  logic [7:0]  ref_mem [int];

  function automatic logic [7:0] ref_rd(int a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return 8'h00;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: compute the expectation from the requirements, then drive one cycle.
  task automatic access(bit wr, logic [23:0] a, logic [1:0] sz, logic [31:0] d, string tag);
    exp_t        e;
    logic [20:0] m;
    int          n;
    bit          al;
    case (cur_reach)
      2'd0:    m = 21'h07_FFFF;
      2'd1:    m = 21'h0F_FFFF;
      default: m = 21'h1F_FFFF;
    endcase
    n  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    al = (sz == 2'd0) || (sz == 2'd1 && !a[0]) || (sz == 2'd2 && a[1:0] == 2'b00);
    e.is_wr = wr;
    e.addr  = a;
    e.tag   = tag;
    e.off   = a[20:0] & m;
    e.hit   = (a < 24'h20_0000) && al && n != 0 &&
              (int'(e.off) + n <= int'(fitted_size));
    e.als   = e.hit && (e.off != a[20:0]);
    e.rdata = 32'hFFFF_FFFF;
    if (e.hit) begin
      if (wr) begin
        for (int i = 0; i < n; i++)
          ref_mem[int'(e.off) + i] = 8'(d >> (8*(n-1-i)));
      end else begin
        e.rdata = '0;
        for (int i = 0; i < n; i++)
          e.rdata = (e.rdata << 8) | {24'd0, ref_rd(int'(e.off) + i)};
      end
    end
    sb.push_back(e);
    wr_en    = wr;
    rd_en    = !wr;
    acc_addr = a;
    acc_size = sz;
    wr_data  = d;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  task automatic idle(int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic set_reach(logic [1:0] r);
    reach_sel = r;
    @(negedge clk);
    cur_reach = r;
  endtask

  // Monitor: pop and compare every response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R13 unexpected response", {11'd0, rsp_offset}, 32'd0);
      end else begin
        bit ok;
        cur = sb.pop_front();
        ok = (rsp_hit == cur.hit) && (rsp_offset == cur.off) && (rsp_alias == cur.als);
        if (cur.is_wr) begin
          ok = ok && (wn_valid == cur.hit) && (!cur.hit || wn_bus_addr == cur.addr) &&
               (wn_chip_valid == (cur.hit && cur.als)) &&
               (!wn_chip_valid || wn_chip_addr == cur.off);
        end else begin
          ok = ok && (rd_data == cur.rdata) && !wn_valid;
        end
        n_checks++;
        if (!ok) begin
          n_fails++;
          $display("FAIL %s: addr=%h hit=%b/%b off=%h/%h alias=%b/%b data=%h/%h wn=%b chipnote=%b/%h",
                   cur.tag, cur.addr, rsp_hit, cur.hit, rsp_offset, cur.off,
                   rsp_alias, cur.als, rd_data, cur.rdata, wn_valid, wn_chip_valid, wn_chip_addr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R13 reset state
    check(!rsp_valid && !ram_en && rd_data == 32'hFFFF_FFFF, "R13 reset",
          {rsp_valid, ram_en, rd_data[29:0]}, 32'h3FFF_FFFF);

    // R8 / R11 / R2: 512 KiB reach, 512 KiB fitted
    access(1, 24'h18_0010, 2'd2, 32'hDEAD_BEEF, "R8 R11 long write via alias");
    access(0, 24'h10_0012, 2'd1, 0, "R8 word read low half");
    access(0, 24'h00_0010, 2'd0, 0, "R8 byte msb first");
    access(0, 24'h00_0010, 2'd2, 0, "R8 long canonical");
    access(0, 24'h08_0013, 2'd0, 0, "R2 R10 byte via alias");
    access(1, 24'h06_0000, 2'd0, 32'h0000_00A5, "R11 canonical write no chip note");
    access(0, 24'h0E_0000, 2'd0, 0, "R2 image 0x080000");
    access(0, 24'h16_0000, 2'd0, 0, "R2 image 0x100000");
    access(0, 24'h1E_0000, 2'd0, 0, "R2 image 0x180000");
    access(1, 24'h1E_0004, 2'd0, 32'h0000_0077, "R11 alias byte write");
    access(0, 24'h06_0004, 2'd0, 0, "R2 alias write landed");
    access(1, 24'h07_FFFC, 2'd2, 32'h1234_5678, "R5 last long fits");
    access(0, 24'h07_FFFC, 2'd2, 0, "R5 last long read");

    // R1 window
    access(0, 24'h20_0000, 2'd0, 0, "R1 R6 read past window");
    access(1, 24'h26_0004, 2'd0, 32'h0000_0055, "R1 R6 write past window");
    access(0, 24'h06_0004, 2'd0, 0, "R6 dropped write left RAM");

    // R9 alignment and reserved size
    access(0, 24'h00_0011, 2'd1, 0, "R9 odd word");
    access(0, 24'h00_0012, 2'd2, 0, "R9 misaligned long");
    access(0, 24'h00_0010, 2'd3, 0, "R9 reserved size");

    // R3: 1 MiB reach, 512 KiB fitted
    set_reach(2'd1);
    access(0, 24'h0E_0000, 2'd0, 0, "R3 R6 unfitted bank open bus");
    access(0, 24'h16_0000, 2'd0, 0, "R3 A20 image");
    access(1, 24'h0E_0000, 2'd0, 32'h0000_0011, "R3 R6 write to unfitted");
    access(0, 24'h06_0000, 2'd0, 0, "R6 canonical unchanged");

    // R5 straddle: fitted ends two bytes into a word group
    fitted_size = 22'h08_0002;
    idle(1);
    access(1, 24'h08_0000, 2'd1, 32'h0000_C0DE, "R5 word ends at limit");
    access(0, 24'h08_0000, 2'd1, 0, "R5 word read at limit");
    access(0, 24'h08_0000, 2'd2, 0, "R5 straddling long misses");

    // R4: 2 MiB reach, full fit
    fitted_size = 22'h20_0000;
    set_reach(2'd2);
    access(1, 24'h1E_0000, 2'd0, 32'h0000_003C, "R4 high write");
    access(0, 24'h1E_0000, 2'd0, 0, "R4 R10 no alias");
    access(0, 24'h06_0000, 2'd0, 0, "R4 low cell distinct");
    fitted_size = 22'h08_0000;
    idle(1);
    access(0, 24'h16_0000, 2'd0, 0, "R4 no mirror past fitted");
    set_reach(2'd3);
    access(0, 24'h16_0000, 2'd0, 0, "R4 reserved reach decodes full");

    // R7 zero fitted
    fitted_size = '0;
    idle(1);
    access(0, 24'h00_0010, 2'd0, 0, "R7 read zero fitted");
    access(1, 24'h00_0010, 2'd0, 32'h0000_0099, "R7 write zero fitted");
    fitted_size = 22'h08_0000;
    idle(1);

    // R12: reach change coinciding with an access is deferred
    set_reach(2'd0);
    reach_sel = 2'd2;
    access(0, 24'h16_0000, 2'd0, 0, "R12 old reach used");
    @(negedge clk);
    cur_reach = 2'd2;
    access(0, 24'h16_0000, 2'd0, 0, "R12 new reach after idle");

    idle(3);
    check(sb.size() == 0, "R13 all responses seen", sb.size(), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule